// File: doc/BRIEF.md
# Bit Manipulation and Test Unit

This block carries out the single-bit instructions of a small 8-bit accumulator-style controller core. Each issued operation names one of four actions (force a bit low, force a bit high, request a skip when a bit is low, request a skip when a bit is high), a register address and a bit index. The unit registers the operation, reads the addressed byte through a register-file read port in the following cycle and, in that same cycle, either presents a modified byte on the write port or raises a skip request to the instruction sequencer.

The register file is external: its read port is combinational and its write port commits on the rising clock edge. Because an operation's write is committed at the edge that ends its execute cycle, the next operation reads the updated byte without any forwarding. One operation can be issued on every clock. Status flags are never involved. The test actions report through the skip line alone.

Top module: `bitop_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `rf_wr_en` and `skip_req` are both low.
- R2: An operation issued with class code 1 (clear) leads, in the cycle after issue, to `rf_wr_en` high, `rf_wr_addr` equal to the issued address, and `rf_wr_data` equal to the byte read with the indexed bit at 0 and the other seven bits unchanged.
- R3: Class code 2 (set) behaves as R2 except that the indexed bit of `rf_wr_data` is 1.
- R4: Class code 3 (test, skip when clear) raises `skip_req` in the cycle after issue exactly when the indexed bit of the byte read is 0.
- R5: Class code 4 (test, skip when set) raises `skip_req` in the cycle after issue exactly when the indexed bit of the byte read is 1.
- R6: Test classes (codes 3 and 4) never assert `rf_wr_en`.
- R7: Set and clear (codes 1 and 2) never assert `skip_req`.
- R8: Class code 0 (idle) and the unused codes 5, 6 and 7 produce neither a write nor a skip in the following cycle.
- R9: In the cycle after an operation with class code 1 to 4 is issued, `rf_rd_addr` equals the issued address; the bit index covers 0 to 7, bit 0 being the least significant.
- R10: Operations issued on consecutive cycles to the same register see each other's results: an operation reads the byte as left by the operation issued one cycle before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_class | input | 3 | Operation class: 0 idle, 1 clear, 2 set, 3 skip if clear, 4 skip if set |
| op_addr | input | 7 | Register address of the operation |
| op_bit | input | 3 | Index of the bit within the addressed byte |
| rf_rd_addr | output | 7 | Register-file read address |
| rf_rd_data | input | 8 | Register-file read data, combinational from `rf_rd_addr` |
| rf_wr_en | output | 1 | Register-file write strobe, committed on the next rising edge |
| rf_wr_addr | output | 7 | Register-file write address |
| rf_wr_data | output | 8 | Register-file write data |
| skip_req | output | 1 | Request to the sequencer to discard the next instruction |

## Verification
Every result is due exactly one clock after the operation is applied: the operation is captured on a rising edge, and the read address, write strobe, write data and skip request are all valid through the following cycle, the write landing at the edge after that. The bench applies a new operation at each falling edge and, at the next falling edge, compares all outputs against a model that holds its own copy of the register contents and advances it by one operation per cycle. Back-to-back operations on the same address are included so that the write-then-read ordering between neighbouring operations is exercised.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [2:0] {
    BOP_IDLE = 3'd0,
    BOP_CLR  = 3'd1,
    BOP_SET  = 3'd2,
    BOP_TSTC = 3'd3,
    BOP_TSTS = 3'd4
  } bop_class_e;

  function automatic logic bop_is_write(input logic [2:0] c);
    return (c == BOP_CLR) || (c == BOP_SET);
  endfunction

  function automatic logic bop_is_test(input logic [2:0] c);
    return (c == BOP_TSTC) || (c == BOP_TSTS);
  endfunction

  function automatic logic bop_is_known(input logic [2:0] c);
    return bop_is_write(c) || bop_is_test(c);
  endfunction

endpackage

// File: rtl/bitop_issue.sv
module bitop_issue
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_class,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [IDX_W-1:0]  op_bit,
  output logic [2:0]        ex_class,
  output logic [ADDR_W-1:0] ex_addr,
  output logic [IDX_W-1:0]  ex_bit
);

  logic [2:0]        class_d;
  logic [ADDR_W-1:0] addr_d;
  logic [IDX_W-1:0]  bit_d;
  logic              operand_en;

  // Operands only load for a real operation; unknown classes collapse to idle.
  always_comb begin
    operand_en = bop_is_known(op_class);
    class_d    = operand_en ? op_class : BOP_IDLE;
    addr_d     = ex_addr;
    bit_d      = ex_bit;
    if (operand_en) begin
      addr_d = op_addr;
      bit_d  = op_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_class <= BOP_IDLE;
      ex_addr  <= '0;
      ex_bit   <= '0;
    end else begin
      ex_class <= class_d;
      ex_addr  <= addr_d;
      ex_bit   <= bit_d;
    end
  end

  assert_invalid_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bop_is_known(op_class) |=> (ex_class == BOP_IDLE));

endmodule

// File: rtl/bitop_mask.sv
module bitop_mask #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] mask
);

  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    assign mask[g] = (idx == IDX_W'(g));
  end

endmodule

// File: rtl/bitop_exec.sv
module bitop_exec
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        ex_class,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              skip
);

  logic sel_val;

  always_comb begin
    sel_val = |(rd_data & mask);
    wr_en   = bop_is_write(ex_class);
    wr_data = (ex_class == BOP_SET) ? (rd_data | mask) : (rd_data & ~mask);
    skip    = ((ex_class == BOP_TSTC) && !sel_val) ||
              ((ex_class == BOP_TSTS) &&  sel_val);
  end

  assert_clear_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_class == BOP_CLR) |-> (((wr_data & mask) == '0) && ((wr_data | mask) == (rd_data | mask))));

  assert_set_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_class == BOP_SET) |-> (((wr_data & mask) == mask) && ((wr_data & ~mask) == (rd_data & ~mask))));

  assert_skip_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> bop_is_test(ex_class));

  assert_test_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bop_is_test(ex_class) |-> !wr_en);

  assert_write_no_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !skip);

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_class,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [IDX_W-1:0]  op_bit,
  output logic [ADDR_W-1:0] rf_rd_addr,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              rf_wr_en,
  output logic [ADDR_W-1:0] rf_wr_addr,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              skip_req
);

  logic [2:0]        ex_class;
  logic [ADDR_W-1:0] ex_addr;
  logic [IDX_W-1:0]  ex_bit;
  logic [DATA_W-1:0] lane_mask;

  bitop_issue #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_issue (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_class (op_class),
    .op_addr  (op_addr),
    .op_bit   (op_bit),
    .ex_class (ex_class),
    .ex_addr  (ex_addr),
    .ex_bit   (ex_bit)
  );

  bitop_mask #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mask (
    .idx  (ex_bit),
    .mask (lane_mask)
  );

  bitop_exec #(.DATA_W(DATA_W)) u_exec (
    .clk     (clk),
    .rst_n   (rst_n),
    .ex_class(ex_class),
    .mask    (lane_mask),
    .rd_data (rf_rd_data),
    .wr_en   (rf_wr_en),
    .wr_data (rf_wr_data),
    .skip    (skip_req)
  );

  assign rf_rd_addr = ex_addr;
  assign rf_wr_addr = ex_addr;

  assert_rd_addr_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bop_is_known(op_class) |=> (rf_rd_addr == $past(op_addr)));

  assert_unknown_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bop_is_known(op_class) |=> (!rf_wr_en && !skip_req));

endmodule

// File: tb/bitop_unit_bench.sv
module bitop_unit_bench;

  logic       clk;
  logic       rst_n;
  logic [2:0] op_class;
  logic [6:0] op_addr;
  logic [2:0] op_bit;
  logic [6:0] rf_rd_addr;
  logic [7:0] rf_rd_data;
  logic       rf_wr_en;
  logic [6:0] rf_wr_addr;
  logic [7:0] rf_wr_data;
  logic       skip_req;

  int n_checks = 0;
  int n_err    = 0;

  logic [7:0] rf_mem  [128];
  logic [7:0] ref_mem [128];

  logic [2:0] pend_class;
  logic [6:0] pend_addr;
  logic [2:0] pend_bit;

  bitop_unit u_bitop_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_class   (op_class),
    .op_addr    (op_addr),
    .op_bit     (op_bit),
    .rf_rd_addr (rf_rd_addr),
    .rf_rd_data (rf_rd_data),
    .rf_wr_en   (rf_wr_en),
    .rf_wr_addr (rf_wr_addr),
    .rf_wr_data (rf_wr_data),
    .skip_req   (skip_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign rf_rd_data = rf_mem[rf_rd_addr];
  always @(posedge clk) if (rf_wr_en) rf_mem[rf_wr_addr] <= rf_wr_data;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Compare the outputs of the operation issued one cycle ago, then advance the model.
  task automatic compare_pending(input string extra);
    string tag;
    int    exp_wr, exp_skip, cur, sel, nxt;
    cur = ref_mem[pend_addr];
    sel = (cur >> pend_bit) & 1;
    exp_wr = 0; exp_skip = 0; nxt = cur;
    case (pend_class)
      3'd1: begin tag = "R2"; exp_wr = 1; nxt = cur & ~(1 << pend_bit) & 8'hFF; end
      3'd2: begin tag = "R3"; exp_wr = 1; nxt = (cur | (1 << pend_bit)) & 8'hFF; end
      3'd3: begin tag = "R4"; exp_skip = (sel == 0) ? 1 : 0; end
      3'd4: begin tag = "R5"; exp_skip = sel; end
      default: tag = "R8";
    endcase
    if (extra.len() > 0) tag = {tag, "/", extra};
    if (pend_class == 3'd3 || pend_class == 3'd4)
      chk({tag, "/R6"}, "rf_wr_en", int'(rf_wr_en), 0);
    else
      chk(tag, "rf_wr_en", int'(rf_wr_en), exp_wr);
    if (exp_wr != 0)
      chk({tag, "/R7"}, "skip_req", int'(skip_req), 0);
    else
      chk(tag, "skip_req", int'(skip_req), exp_skip);
    if (exp_wr != 0) begin
      chk(tag, "rf_wr_addr", int'(rf_wr_addr), int'(pend_addr));
      chk(tag, "rf_wr_data", int'(rf_wr_data), nxt);
    end
    if (pend_class >= 3'd1 && pend_class <= 3'd4)
      chk({tag, "/R9"}, "rf_rd_addr", int'(rf_rd_addr), int'(pend_addr));
    if (exp_wr != 0) ref_mem[pend_addr] = nxt[7:0];
  endtask

  task automatic step(input logic [2:0] c, input logic [6:0] a, input logic [2:0] b,
                      input string extra);
    @(negedge clk);
    compare_pending(extra);
    op_class   = c;
    op_addr    = a;
    op_bit     = b;
    pend_class = c;
    pend_addr  = a;
    pend_bit   = b;
  endtask

  initial begin
    #1_500_000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      rf_mem[i]  = 8'((i * 37 + 5) ^ (i << 3));
      ref_mem[i] = rf_mem[i];
    end
    rst_n = 1'b0; op_class = 3'd0; op_addr = '0; op_bit = '0;
    pend_class = 3'd0; pend_addr = '0; pend_bit = '0;
    repeat (3) @(negedge clk);
    chk("R1", "rf_wr_en in reset", int'(rf_wr_en), 0);
    chk("R1", "skip_req in reset", int'(skip_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rf_wr_en after reset", int'(rf_wr_en), 0);
    chk("R1", "skip_req after reset", int'(skip_req), 0);

    // Every bit index with each class on fixed registers.
    for (int b = 0; b < 8; b++) begin
      step(3'd2, 7'd20, 3'(b), "");
      step(3'd4, 7'd20, 3'(b), "");
      step(3'd3, 7'd20, 3'(b), "");
      step(3'd1, 7'd21, 3'(b), "");
      step(3'd3, 7'd21, 3'(b), "");
      step(3'd4, 7'd21, 3'(b), "");
    end
    // Boundary addresses.
    step(3'd1, 7'd0,   3'd7, "");
    step(3'd2, 7'd127, 3'd0, "");
    step(3'd4, 7'd127, 3'd0, "");
    // Idle and unused codes, then a test to confirm nothing changed.
    for (int c = 5; c < 8; c++) step(3'(c), 7'd30, 3'd2, "");
    step(3'd0, 7'd30, 3'd2, "");
    step(3'd4, 7'd30, 3'd2, "");
    // R10: back-to-back dependent operations on one register.
    step(3'd2, 7'd40, 3'd5, "R10");
    step(3'd4, 7'd40, 3'd5, "R10");
    step(3'd1, 7'd40, 3'd5, "R10");
    step(3'd3, 7'd40, 3'd5, "R10");
    step(3'd2, 7'd40, 3'd1, "R10");
    step(3'd2, 7'd40, 3'd6, "R10");
    step(3'd1, 7'd40, 3'd1, "R10");
    // Mixed traffic over a narrow address window to create dependencies.
    for (int n = 0; n < 600; n++)
      step(3'($urandom_range(0, 7)), 7'($urandom_range(0, 15)), 3'($urandom_range(0, 7)), "");
    for (int n = 0; n < 200; n++)
      step(3'($urandom_range(1, 4)), 7'($urandom_range(0, 127)), 3'($urandom_range(0, 7)), "");
    step(3'd0, 7'd0, 3'd0, "");
    step(3'd0, 7'd0, 3'd0, "");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule